// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block reproduces the digital timing of a delta-sigma converter's control path. All timing is counted in master-clock cycles. A conversion runs for a fixed number of cycles. At the end of it, a 24-bit result is latched from a test sample input and the active-low ready strobe falls. The analog modulator, the filter arithmetic and the serial port are not modelled. Sample data enters on a plain input bus.

The active-low convert request sets the conversion rate. Held low, it makes conversions run back to back. Tied to the ready strobe, it makes each conversion start a little after the previous result appears. Pulsed from an unrelated clock domain, it starts one conversion after a short synchroniser delay. An active-low sleep input aborts any conversion in flight and parks the block. Leaving sleep starts a fixed wake-up interval, during which convert requests are ignored. The polarity select decides how the latched word is coded.

Top module: `adc_conv_seq`

## Requirements
- R1: With conv_ni held low and the block awake, rdy_no falls once every PERIOD (1600) clock cycles, with no idle cycles between conversions.
- R2: With conv_ni driven from rdy_no and each result read, the distance between successive rdy_no falling edges is PERIOD+2 (1602) cycles.
- R3: conv_ni passes through a two-stage synchroniser. When conv_ni falls between edge k and edge k+1 with the block idle, rdy_no falls on edge k+1602, which is within 1604 cycles. With conv_ni held high, no conversion starts.
- R4: While rst_ni is low, rdy_no is 1, data_o is 0 and no conversion runs. When rst_ni is released after edge k with conv_ni low, the first rdy_no fall is on edge k+1602.
- R5: Two instances that share clock, reset and inputs, and are released from reset together, produce identical rdy_no and data_o on every cycle.
- R6: Once sleep_ni is low, any conversion in flight is aborted, rdy_no stays 1 and conv_ni is ignored.
- R7: When sleep_ni rises after edge k with conv_ni low, a wake interval of WAKE (3083) cycles must pass before a conversion starts. The first rdy_no fall is on edge k+WAKE+PERIOD+3.
- R8: viol_o is 1 exactly when rst_ni and sleep_ni are both low.
- R9: On the cycle a conversion completes, data_o takes sample_i. With bipolar_i=1 the word is kept as two's complement. With bipolar_i=0, bit 23 is inverted to give offset binary.
- R10: rdy_no returns to 1 on the edge after rd_i is sampled high, or one cycle before the next completion, whichever comes first. data_o changes only on a completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_ni | input | 1 | Convert request, active low, may be asynchronous |
| sleep_ni | input | 1 | Sleep request, active low, may be asynchronous |
| bipolar_i | input | 1 | 1: two's-complement result, 0: offset-binary result |
| rd_i | input | 1 | Result read strobe, releases rdy_no |
| sample_i | input | 24 | Test sample, latched at conversion completion |
| rdy_no | output | 1 | Result ready, active low |
| data_o | output | 24 | Coded conversion result |
| viol_o | output | 1 | Reset asserted while asleep |

## Verification
The assertions hold on every cycle. They check that rdy_no falls only right after a completion, that completions are at least one conversion period apart, and that the wake interval lasts exactly WAKE cycles. They also check that no completion or ready strobe occurs while asleep or waking, that a read releases the strobe, and that data_o changes only at a completion and carries the correct coding. The exact ready timings under each way of driving conv_ni can only be shown by the bench's scenarios: back to back, self-triggered, a single asynchronous request, release from reset, and wake from sleep. The same holds for the equality of two instances started together and for the reset-during-sleep flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int PERIOD = 1600,
  parameter int WAKE   = 3083
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       conv_si,
  input  logic       awake_si,
  input  logic       rd_i,
  output logic       done_o,
  output logic       rdy_no,
  output seq_state_e state_o
);
  localparam int LIM   = (PERIOD > WAKE) ? PERIOD : WAKE;
  localparam int CNT_W = $clog2(LIM + 1);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(PERIOD - 2);
  localparam logic [CNT_W-1:0] LAST_W = CNT_W'(WAKE - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done, pre_done;

  assign done     = awake_si && (state_q == ST_CONV) && (cnt_q == LAST_C);
  assign pre_done = awake_si && (state_q == ST_CONV) && (cnt_q == PRE_C);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!awake_si) begin
      state_d = ST_SLEEP;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (!conv_si) begin
          // request-detect cycle counts as the first conversion cycle
          state_d = ST_CONV;
          cnt_d   = ONE;
        end
        ST_CONV: if (cnt_q == LAST_C) begin
          cnt_d = '0;
          if (conv_si) state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
        ST_SLEEP: begin
          state_d = ST_WAKE;
          cnt_d   = '0;
        end
        ST_WAKE: if (cnt_q == LAST_W) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             rdy_no <= 1'b1;
    else if (done)                           rdy_no <= 1'b0;
    else if (!awake_si || rd_i || pre_done)  rdy_no <= 1'b1;
  end

  assign done_o  = done;
  assign state_o = state_q;
endmodule

// File: rtl/adc_seq_coder.sv
module adc_seq_coder #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              bipolar_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] coded;

  // offset binary: flip the sign bit of the two's-complement value
  assign coded = {sample_i[DATA_W-1] ^ ~bipolar_i, sample_i[DATA_W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (load_i) data_o <= coded;
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int PERIOD = 1600,
  parameter int WAKE   = 3083,
  parameter int SYNC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_ni,
  input  logic              sleep_ni,
  input  logic              bipolar_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              rdy_no,
  output logic [DATA_W-1:0] data_o,
  output logic              viol_o
);
  logic       conv_s, awake_s, done;
  seq_state_e state;

  adc_seq_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_conv_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (conv_ni),
    .q_o   (conv_s)
  );

  adc_seq_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_sleep_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sleep_ni),
    .q_o   (awake_s)
  );

  adc_seq_fsm #(.PERIOD(PERIOD), .WAKE(WAKE)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .conv_si (conv_s),
    .awake_si(awake_s),
    .rd_i    (rd_i),
    .done_o  (done),
    .rdy_no  (rdy_no),
    .state_o (state)
  );

  adc_seq_coder #(.DATA_W(DATA_W)) u_coder (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (done),
    .bipolar_i(bipolar_i),
    .sample_i (sample_i),
    .data_o   (data_o)
  );

  assign viol_o = ~rst_ni & ~sleep_ni;
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int PERIOD = 1600,
  parameter int WAKE   = 3083
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              bipolar_i,
  input logic [DATA_W-1:0] sample_i,
  input logic              rdy_no,
  input logic [DATA_W-1:0] data_o,
  input logic              done_i,
  input seq_state_e        state_i
);
  logic [31:0] gap_q, wk_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      wk_q   <= '0;
    end else begin
      gap_q  <= done_i ? 32'd0 : gap_q + 32'd1;
      seen_q <= seen_q | done_i;
      wk_q   <= (state_i == ST_WAKE) ? wk_q + 32'd1 : 32'd0;
    end
  end

  AST_FALL_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_no) |-> $past(done_i)); // R10
  AST_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && seen_q) |-> (gap_q >= 32'(PERIOD - 1))); // R1
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(data_o)); // R10
  AST_CODE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (data_o[DATA_W-2:0] == $past(sample_i[DATA_W-2:0]))); // R9
  AST_CODE_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (data_o[DATA_W-1] == ($past(sample_i[DATA_W-1]) ^ !$past(bipolar_i)))); // R9
  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SLEEP || state_i == ST_WAKE) |-> (rdy_no && !done_i)); // R6
  AST_READ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> rdy_no); // R10
  AST_WAKE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && $past(state_i) == ST_WAKE) |-> (wk_q == 32'(WAKE))); // R7
endmodule

bind adc_conv_seq adc_conv_seq_chk #(
  .DATA_W(DATA_W), .PERIOD(PERIOD), .WAKE(WAKE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .bipolar_i(bipolar_i),
  .sample_i (sample_i),
  .rdy_no   (rdy_no),
  .data_o   (data_o),
  .done_i   (done),
  .state_i  (state)
);

// File: tb/sim_adc_conv_seq.sv
module sim_adc_conv_seq;
  localparam int P = 1600;
  localparam int W = 3083;

  // {bipolar, sample, expected}
  localparam logic [48:0] VEC [0:5] = '{
    {1'b0, 24'h800000, 24'h000000},
    {1'b0, 24'h7FFFFF, 24'hFFFFFF},
    {1'b0, 24'h000000, 24'h800000},
    {1'b1, 24'hFFFFFF, 24'hFFFFFF},
    {1'b1, 24'h123456, 24'h123456},
    {1'b0, 24'h123456, 24'h923456}
  };

  logic        clk = 1'b0;
  logic        rst_n, conv_n, sleep_n, bip, rd;
  logic [23:0] sample;
  logic        rdy0, rdy1, viol0, viol1;
  logic [23:0] data0, data1;
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  int          mism = 0;
  bit          tie = 1'b0;
  bit          rdy_prev = 1'b1;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_conv_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .conv_ni(conv_n), .sleep_ni(sleep_n),
    .bipolar_i(bip), .rd_i(rd), .sample_i(sample),
    .rdy_no(rdy0), .data_o(data0), .viol_o(viol0)
  );

  adc_conv_seq u1 (
    .clk_i(clk), .rst_ni(rst_n), .conv_ni(conv_n), .sleep_ni(sleep_n),
    .bipolar_i(bip), .rd_i(rd), .sample_i(sample),
    .rdy_no(rdy1), .data_o(data1), .viol_o(viol1)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    rdy_prev = rdy0;
    @(negedge clk);
    if (rdy0 !== rdy1 || data0 !== data1 || viol0 !== viol1) mism++;
    if (tie) conv_n = rdy0;
  endtask

  task automatic wait_fall(output int t);
    step();
    while (!(rdy_prev && !rdy0)) step();
    t = cyc;
  endtask

  task automatic do_read();
    rd = 1'b1;
    step();
    rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL R1: watchdog expired at cycle %0d, expected completion before %0d", cyc, 200000);
    finish_run();
  end

  initial begin
    int k, t, t2, tp, tf, tg, th, a, b, c, d, e, falls;
    rst_n = 1'b0; conv_n = 1'b0; sleep_n = 1'b1; bip = 1'b1; rd = 1'b0;
    sample = 24'hA5A5A5;
    repeat (5) step();
    chk(rdy0 == 1'b1, "R4", rdy0, 1);
    chk(data0 == 24'h0, "R4", data0, 0);
    sleep_n = 1'b0; #1;
    chk(viol0 == 1'b1, "R8", viol0, 1);
    sleep_n = 1'b1; #1;
    chk(viol0 == 1'b0, "R8", viol0, 0);
    step();

    // reset release with conv held low
    k = cyc;
    rst_n = 1'b1;
    wait_fall(t);
    chk(t == k + P + 2, "R4", t - k, P + 2);
    wait_fall(t2);
    chk(t2 - t == P, "R1", t2 - t, P);

    // coding vectors, back-to-back conversions
    tp = t2;
    for (int i = 0; i < 6; i++) begin
      bip    = VEC[i][48];
      sample = VEC[i][47:24];
      wait_fall(tf);
      chk(data0 == VEC[i][23:0], "R9", data0, VEC[i][23:0]);
      chk(tf - tp == P, "R1", tf - tp, P);
      tp = tf;
    end

    // ready release by read, data hold
    repeat (3) step();
    chk(rdy0 == 1'b0, "R10", rdy0, 0);
    do_read();
    chk(rdy0 == 1'b1, "R10", rdy0, 1);
    while (cyc < tf + P - 1) step();
    chk(data0 == 24'h923456, "R10", data0, 24'h923456);
    wait_fall(tg);
    while (cyc < tg + P - 1) step();
    chk(rdy0 == 1'b1, "R10", rdy0, 1);
    wait_fall(th);
    chk(th - tg == P, "R1", th - tg, P);

    // self-triggered: conv follows ready
    tie = 1'b1;
    repeat (10) step();
    do_read();
    wait_fall(a);
    repeat (10) step();
    do_read();
    wait_fall(b);
    chk(b - a == P + 2, "R2", b - a, P + 2);
    repeat (10) step();
    do_read();
    wait_fall(c);
    chk(c - b == P + 2, "R2", c - b, P + 2);
    tie = 1'b0;
    conv_n = 1'b1;
    repeat (10) step();
    do_read();
    repeat (20) step();

    // single asynchronous request
    k = cyc;
    conv_n = 1'b0;
    repeat (5) step();
    conv_n = 1'b1;
    wait_fall(d);
    chk(d - k == P + 2, "R3", d - k, P + 2);
    chk(d - k <= 1604, "R3", d - k, 1604);
    do_read();
    falls = 0;
    for (int i = 0; i < P + 10; i++) begin
      step();
      if (rdy_prev && !rdy0) falls++;
    end
    chk(falls == 0, "R3", falls, 0);

    // sleep aborts a running conversion
    conv_n = 1'b0;
    repeat (100) step();
    sleep_n = 1'b0;
    #1;
    chk(viol0 == 1'b0, "R8", viol0, 0);
    falls = 0;
    for (int i = 0; i < P + 10; i++) begin
      step();
      if (!rdy0) falls++;
    end
    chk(falls == 0, "R6", falls, 0);

    // wake latency
    k = cyc;
    sleep_n = 1'b1;
    wait_fall(e);
    chk(e - k == W + P + 3, "R7", e - k, W + P + 3);

    chk(mism == 0, "R5", mism, 0);
    finish_run();
  end
endmodule